// File: doc/BRIEF.md
# Triggered ADC Conversion Sequencer

This block is the digital control for a successive-approximation analog-to-digital converter. Software programs a small control word that holds an enable bit, a start/busy bit, a three-bit acquisition-length code and a two-bit source selector. A conversion begins in one of two ways: software sets the start bit, or a pulse arrives on the selected one of four hardware trigger lines. The sequencer then runs an optional acquisition phase with the sample switch closed. After that it performs twelve binary-search steps against an external comparator, one step per TAD clock-enable tick, and stores the result right-justified in a 16-bit result register.

Software can abort a running conversion. An abort leaves the stored result as it was. After every completion or abort the sequencer holds the sample switch open for two TAD ticks. Once that wait ends, and while the block is enabled, sampling of the input resumes on its own. A one-cycle done pulse signals each completed conversion. The sample-and-hold, the DAC, the comparator and the channel multiplexer are outside the block and appear only as ports.

Top module: `adc_seq_ctrl`

## Requirements
- R1: The control word bits [6:5] select the hardware trigger source. Code k selects `trig_in[k]`: 3 is the real-time-clock alarm, 2 is the timer overflow, 1 is the charge-time unit and 0 is the capture/compare event. Pulses on the other lines have no effect.
- R2: While the enable bit (control bit 0) reads 0, a trigger pulse is ignored and `busy_o` stays 0.
- R3: While the block is enabled and idle, a pulse on the selected trigger starts a conversion, and so does a control write with bit 0 = 1 and bit 1 (start) = 1. In either case `busy_o` is 1 in the next cycle and `sample_on` stays 1 during acquisition.
- R4: A control write with start = 0 (or enable = 0) while `busy_o` is 1 aborts at once: `busy_o` is 0 in the next cycle and no done pulse follows.
- R5: Control bits [4:2] set the acquisition length. Codes 0 to 7 give 0, 2, 4, 6, 8, 12, 16 and 20 TAD ticks. With code 0, conversion starts on the first tick after the start.
- R6: A conversion takes exactly 12 ticks and resolves the MSB first. A bit is kept when `cmp_in` is 1 (input at or above `dac_code`). At the end, `result` holds the 12-bit code zero-extended to 16 bits, `done` is high for exactly one cycle, and `busy_o` is 0 in that same cycle.
- R7: After a completion or an abort, `sample_on` stays 0 for exactly 2 ticks. Then, if the block is enabled, it returns to 1 without any new start.
- R8: An aborted conversion leaves `result` holding the last completed result or the last value written through `res_we`/`res_wdata`.
- R9: A single control write that sets enable and start together, while enable was 0, starts nothing.
- R10: A trigger pulse that arrives while `busy_o` is 1, or during the 2-tick wait, is dropped and never starts a later conversion.
- R11: After reset, `en_o`, `busy_o`, `sample_on` and `done` are 0 and `result` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Control word write strobe |
| cfg_wdata | input | 7 | Control word: [0] enable, [1] start, [4:2] acquisition code, [6:5] trigger select |
| res_we | input | 1 | Software write strobe for the result register |
| res_wdata | input | 16 | Value written to the result register |
| trig_in | input | 4 | Hardware trigger pulses, one per source |
| tad_tick | input | 1 | TAD clock-enable tick |
| cmp_in | input | 1 | Comparator: 1 when the analog input is at or above `dac_code` |
| en_o | output | 1 | Current enable bit |
| busy_o | output | 1 | Start/busy bit: acquisition or conversion in progress |
| sample_on | output | 1 | Sample switch closed |
| dac_code | output | 12 | Trial code for the DAC during conversion |
| result | output | 16 | Right-justified conversion result |
| done | output | 1 | One-cycle pulse when a conversion completes |

## Verification
A comparator model in the bench answers for a chosen analog value. Conversions are run at the extreme codes 0 and 4095, at a mixed-bit code and at random codes, so that any wrongly kept or dropped bit position is exposed. Starts alternate between software writes and each of the four trigger lines, and a pulse on a line that is not selected shows whether the source decode is right. Tick counts taken while busy and while the switch is open after each conversion tell the acquisition mapping apart from the conversion length and from the post-conversion wait. Aborts are issued both after a completed result and after a software write to the result register, which separates "keep the old value" from "keep the last completion".

// File: rtl/adc_seq_pkg.sv
package adc_seq_pkg;

  typedef enum logic [1:0] {
    ST_IDLE = 2'd0,
    ST_ACQ  = 2'd1,
    ST_CONV = 2'd2,
    ST_WAIT = 2'd3
  } seq_state_t;

  // Acquisition code to tick count: steps of 2 up to code 4, then steps of 4.
  function automatic int unsigned acq_tads(input int unsigned code);
    if (code <= 32'd4) return 2 * code;
    else               return 4 * (code - 2);
  endfunction

endpackage

// File: rtl/adc_rst_sync.sv
module adc_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic meta_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q     <= 1'b0;
      rst_sync_n <= 1'b0;
    end else begin
      meta_q     <= 1'b1;
      rst_sync_n <= meta_q;
    end
  end
endmodule

// File: rtl/adc_trig_sel.sv
module adc_trig_sel #(
  parameter int unsigned TRIG_N = 4,
  parameter int unsigned TSEL_W = 2
) (
  input  logic [TRIG_N-1:0] trig_in,
  input  logic [TSEL_W-1:0] sel,
  output logic              hit
);
  logic [TRIG_N-1:0] gated;

  for (genvar k = 0; k < TRIG_N; k++) begin : g_src
    assign gated[k] = trig_in[k] && (sel == TSEL_W'(k));
  end

  assign hit = |gated;
endmodule

// File: rtl/adc_tad_counter.sv
module adc_tad_counter #(
  parameter int unsigned CNT_W = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             load,
  input  logic [CNT_W-1:0] load_val,
  input  logic             tick,
  output logic             expire
);
  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (load)                           cnt_d = load_val;
    else if (tick && (cnt_q != '0))     cnt_d = cnt_q - CNT_W'(1);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '0;
    else        cnt_q <= cnt_d;
  end

  assign expire = tick && (cnt_q == CNT_W'(1));
endmodule

// File: rtl/adc_sar_core.sv
module adc_sar_core #(
  parameter int unsigned RES_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             init,
  input  logic             step,
  input  logic             cmp,
  output logic [RES_W-1:0] trial,
  output logic             last,
  output logic [RES_W-1:0] final_code
);
  localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

  logic [RES_W-1:0] code_q, code_d;
  logic [RES_W-1:0] mask_q, mask_d;
  logic [RES_W-1:0] kept;

  assign kept = cmp ? code_q : (code_q & ~mask_q);

  always_comb begin
    code_d = code_q;
    mask_d = mask_q;
    if (init) begin
      code_d = TOP_BIT;
      mask_d = TOP_BIT;
    end else if (step) begin
      code_d = kept | (mask_q >> 1);
      mask_d = mask_q >> 1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      code_q <= '0;
      mask_q <= '0;
    end else begin
      code_q <= code_d;
      mask_q <= mask_d;
    end
  end

  assign trial      = code_q;
  assign last       = mask_q[0];
  assign final_code = kept;
endmodule

// File: rtl/adc_seq_ctrl.sv
module adc_seq_ctrl
  import adc_seq_pkg::*;
#(
  parameter int unsigned RES_W     = 12,
  parameter int unsigned OUT_W     = 16,
  parameter int unsigned TRIG_N    = 4,
  parameter int unsigned TSEL_W    = 2,
  parameter int unsigned ACQ_W     = 3,
  parameter int unsigned CNT_W     = 5,
  parameter int unsigned WAIT_TADS = 2
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_we,
  input  logic [ACQ_W+TSEL_W+1:0]   cfg_wdata,
  input  logic                      res_we,
  input  logic [OUT_W-1:0]          res_wdata,
  input  logic [TRIG_N-1:0]         trig_in,
  input  logic                      tad_tick,
  input  logic                      cmp_in,
  output logic                      en_o,
  output logic                      busy_o,
  output logic                      sample_on,
  output logic [RES_W-1:0]          dac_code,
  output logic [OUT_W-1:0]          result,
  output logic                      done
);
  localparam int unsigned BIT_EN   = 0;
  localparam int unsigned BIT_GO   = 1;
  localparam int unsigned ACQ_LSB  = 2;
  localparam int unsigned TSEL_LSB = ACQ_LSB + ACQ_W;
  localparam int unsigned PAD_W    = OUT_W - RES_W;

  logic rst_i_n;

  adc_rst_sync u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  // Control fields
  logic              en_q, en_d;
  logic [ACQ_W-1:0]  acq_q, acq_d;
  logic [TSEL_W-1:0] tsel_q, tsel_d;
  seq_state_t        state_q, state_d;
  logic [OUT_W-1:0]  res_q, res_d;
  logic              done_q, done_d;

  logic wr_en, wr_go;
  assign wr_en = cfg_wdata[BIT_EN];
  assign wr_go = cfg_wdata[BIT_GO];

  always_comb begin
    en_d   = en_q;
    acq_d  = acq_q;
    tsel_d = tsel_q;
    if (cfg_we) begin
      en_d   = wr_en;
      acq_d  = cfg_wdata[ACQ_LSB +: ACQ_W];
      tsel_d = cfg_wdata[TSEL_LSB +: TSEL_W];
    end
  end

  // Start qualification
  logic trig_hit;

  adc_trig_sel #(.TRIG_N(TRIG_N), .TSEL_W(TSEL_W)) u_trig (
    .trig_in (trig_in),
    .sel     (tsel_q),
    .hit     (trig_hit)
  );

  logic in_idle, in_busy, sw_go, hw_go, go, abort;
  logic [CNT_W-1:0] acq_len;

  assign in_idle = (state_q == ST_IDLE);
  assign in_busy = (state_q == ST_ACQ) || (state_q == ST_CONV);
  assign sw_go   = cfg_we && wr_go && wr_en && en_q && in_idle;
  assign hw_go   = trig_hit && en_q && in_idle && !(cfg_we && !wr_en);
  assign go      = sw_go || hw_go;
  assign abort   = in_busy && cfg_we && (!wr_go || !wr_en);
  assign acq_len = CNT_W'(acq_tads(32'(acq_d)));

  // Shared tick counter: acquisition length and post-conversion wait
  logic             cnt_load, cnt_expire;
  logic [CNT_W-1:0] cnt_val;
  logic             sar_init, sar_step, sar_last, conv_fin;
  logic [RES_W-1:0] sar_trial, sar_final;

  assign conv_fin = sar_step && sar_last;
  assign cnt_load = go || abort || conv_fin;
  assign cnt_val  = go ? acq_len : CNT_W'(WAIT_TADS);

  adc_tad_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk      (clk),
    .rst_n    (rst_i_n),
    .load     (cnt_load),
    .load_val (cnt_val),
    .tick     (tad_tick),
    .expire   (cnt_expire)
  );

  assign sar_init = (go && (acq_len == '0)) ||
                    ((state_q == ST_ACQ) && cnt_expire && !abort);
  assign sar_step = (state_q == ST_CONV) && tad_tick && !abort;

  adc_sar_core #(.RES_W(RES_W)) u_sar (
    .clk        (clk),
    .rst_n      (rst_i_n),
    .init       (sar_init),
    .step       (sar_step),
    .cmp        (cmp_in),
    .trial      (sar_trial),
    .last       (sar_last),
    .final_code (sar_final)
  );

  // Sequencer next state
  always_comb begin
    state_d = state_q;
    unique case (state_q)
      ST_IDLE: if (go) state_d = (acq_len == '0) ? ST_CONV : ST_ACQ;
      ST_ACQ: begin
        if (abort)           state_d = ST_WAIT;
        else if (cnt_expire) state_d = ST_CONV;
      end
      ST_CONV: begin
        if (abort || conv_fin) state_d = ST_WAIT;
      end
      ST_WAIT: if (cnt_expire) state_d = ST_IDLE;
      default: state_d = ST_IDLE;
    endcase
  end

  always_comb begin
    res_d  = res_q;
    done_d = conv_fin;
    if (conv_fin)    res_d = {{PAD_W{1'b0}}, sar_final};
    else if (res_we) res_d = res_wdata;
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      en_q    <= 1'b0;
      acq_q   <= '0;
      tsel_q  <= '0;
      state_q <= ST_IDLE;
      res_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      en_q    <= en_d;
      acq_q   <= acq_d;
      tsel_q  <= tsel_d;
      state_q <= state_d;
      res_q   <= res_d;
      done_q  <= done_d;
    end
  end

  assign en_o      = en_q;
  assign busy_o    = in_busy;
  assign sample_on = en_q && (in_idle || (state_q == ST_ACQ));
  assign dac_code  = sar_trial;
  assign result    = res_q;
  assign done      = done_q;
endmodule

// File: rtl/adc_seq_checker.sv
module adc_seq_checker #(
  parameter int unsigned OUT_W = 16
) (
  input logic             clk,
  input logic             rst_n,
  input logic             cfg_we,
  input logic             cfg_go,
  input logic             res_we,
  input logic             en_o,
  input logic             busy_o,
  input logic             done,
  input logic [OUT_W-1:0] result
);
  AST_DISABLED_NO_START: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_o && !busy_o) |=> !busy_o);  // R2

  AST_JOINT_WRITE_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    (!en_o && cfg_we && cfg_go) |=> !busy_o);  // R9

  AST_ABORT_STOPS: assert property (@(posedge clk) disable iff (!rst_n)
    (busy_o && cfg_we && !cfg_go) |=> (!busy_o && !done));  // R4

  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);  // R6

  AST_DONE_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !busy_o);  // R6

  AST_WAIT_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !busy_o);  // R7

  AST_RESULT_SOURCE: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(result) |-> (done || $past(res_we)));  // R8
endmodule

bind adc_seq_ctrl adc_seq_checker #(.OUT_W(OUT_W)) u_chk (
  .clk    (clk),
  .rst_n  (rst_n),
  .cfg_we (cfg_we),
  .cfg_go (cfg_wdata[1]),
  .res_we (res_we),
  .en_o   (en_o),
  .busy_o (busy_o),
  .done   (done),
  .result (result)
);

// File: tb/adc_seq_ctrl_test.sv
module adc_seq_ctrl_test;
  localparam int CLK_PERIOD = 10;
  localparam int TICK_DIV   = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_we = 1'b0;
  logic [6:0]  cfg_wdata = '0;
  logic        res_we = 1'b0;
  logic [15:0] res_wdata = '0;
  logic [3:0]  trig_in = '0;
  logic        tad_tick = 1'b0;
  logic        cmp_in;
  logic        en_o, busy_o, sample_on, done;
  logic [11:0] dac_code;
  logic [15:0] result;
  logic [11:0] vin = '0;

  int checks = 0;
  int errors = 0;
  int div = 0;
  int busy_ticks = 0;
  int wait_ticks = 0;
  int done_seen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  // Comparator model of the analog side
  assign cmp_in = (vin >= dac_code);

  adc_seq_ctrl uut (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata),
    .res_we(res_we), .res_wdata(res_wdata), .trig_in(trig_in),
    .tad_tick(tad_tick), .cmp_in(cmp_in), .en_o(en_o), .busy_o(busy_o),
    .sample_on(sample_on), .dac_code(dac_code), .result(result), .done(done)
  );

  // Tick generation and tick accounting (tick value set here is used at the next edge)
  always @(negedge clk) begin
    div = (div == TICK_DIV - 1) ? 0 : div + 1;
    tad_tick = (div == 0);
    if (busy_o) begin
      if (tad_tick) busy_ticks++;
    end else if (sample_on) begin
      busy_ticks = 0;
    end
    if (busy_o) wait_ticks = 0;
    else if (!sample_on && tad_tick) wait_ticks++;
    if (done) done_seen++;
  end

  function automatic int exp_acq(input int code);
    case (code)
      0: return 0;   1: return 2;   2: return 4;   3: return 6;
      4: return 8;   5: return 12;  6: return 16;  default: return 20;
    endcase
  endfunction

  function automatic logic [6:0] cw(input bit en, input bit go, input int acq, input int tsel);
    return {2'(tsel), 3'(acq), go, en};
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic write_cfg(input bit en, input bit go, input int acq, input int tsel);
    @(negedge clk); cfg_we = 1'b1; cfg_wdata = cw(en, go, acq, tsel);
    @(negedge clk); cfg_we = 1'b0; #1;
  endtask

  task automatic pulse_trig(input logic [3:0] lines);
    @(negedge clk); trig_in = lines;
    @(negedge clk); trig_in = '0; #1;
  endtask

  task automatic write_res(input logic [15:0] v);
    @(negedge clk); res_we = 1'b1; res_wdata = v;
    @(negedge clk); res_we = 1'b0; #1;
  endtask

  task automatic wait_done();
    for (int i = 0; i < 600; i++) begin
      @(negedge clk); #1;
      if (done) return;
    end
    check(1'b0, "R6 done timeout", 0, 1);
  endtask

  task automatic wait_back();
    for (int i = 0; i < 200; i++) begin
      @(negedge clk); #1;
      if (sample_on) return;
    end
    check(1'b0, "R7 sample return timeout", 0, 1);
  endtask

  task automatic wait_busy_ticks(input int n);
    for (int i = 0; i < 300; i++) begin
      @(negedge clk); #1;
      if (busy_ticks >= n) return;
    end
  endtask

  // One complete conversion with all timing checks
  task automatic run_conv(input logic [11:0] v, input int acq, input int tsel, input bit use_trig);
    int d0;
    vin = v;
    write_cfg(1'b1, 1'b0, acq, tsel);
    d0 = done_seen;
    if (use_trig) pulse_trig(4'(1 << tsel));
    else          write_cfg(1'b1, 1'b1, acq, tsel);
    check(busy_o == 1'b1, "R3 busy after start", int'(busy_o), 1);
    wait_done();
    check(result == {4'h0, v}, "R6 result", int'(result), int'(v));
    check(busy_ticks == exp_acq(acq) + 12, "R5 ticks acq+conv", busy_ticks, exp_acq(acq) + 12);
    check(busy_o == 1'b0, "R6 busy cleared with done", int'(busy_o), 0);
    wait_back();
    check(wait_ticks == 2, "R7 wait ticks", wait_ticks, 2);
    check(done_seen == d0 + 1, "R6 one done cycle", done_seen - d0, 1);
  endtask

  initial begin
    int d0;
    logic [15:0] keep;
    void'($urandom(32'd13579));
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    #1;

    // R11 reset state
    check(en_o == 1'b0 && busy_o == 1'b0, "R11 en/busy", int'({en_o, busy_o}), 0);
    check(sample_on == 1'b0 && done == 1'b0, "R11 sample/done", int'({sample_on, done}), 0);
    check(result == 16'h0, "R11 result", int'(result), 0);

    // R2 triggers ignored while disabled
    pulse_trig(4'hF);
    check(busy_o == 1'b0, "R2 trigger ignored", int'(busy_o), 0);
    repeat (5) @(negedge clk); #1;
    check(busy_o == 1'b0, "R2 still idle", int'(busy_o), 0);

    // R9 enable and start in one write
    write_cfg(1'b1, 1'b1, 0, 0);
    check(busy_o == 1'b0 && en_o == 1'b1, "R9 joint write", int'({en_o, busy_o}), 2);
    repeat (3) @(negedge clk); #1;
    check(busy_o == 1'b0, "R9 no late start", int'(busy_o), 0);
    check(sample_on == 1'b1, "R7 sampling while idle", int'(sample_on), 1);

    // R3 sampling during acquisition, R5 code 2 = 4 ticks
    vin = 12'hA5C;
    write_cfg(1'b1, 1'b0, 2, 0);
    write_cfg(1'b1, 1'b1, 2, 0);
    check(busy_o && sample_on, "R3 acquisition samples", int'({busy_o, sample_on}), 3);
    wait_busy_ticks(6);
    check(busy_o && !sample_on, "R6 switch open in conversion", int'({busy_o, sample_on}), 2);
    wait_done();
    check(result == 16'h0A5C, "R6 directed result", int'(result), 16'h0A5C);
    check(busy_ticks == 16, "R5 code 2 ticks", busy_ticks, 16);
    wait_back();
    check(wait_ticks == 2, "R7 wait after done", wait_ticks, 2);

    // Extreme codes with no acquisition delay (R5 code 0)
    run_conv(12'h000, 0, 0, 1'b0);
    run_conv(12'hFFF, 0, 0, 1'b0);
    run_conv(12'h800, 7, 3, 1'b1);

    // R1 each source, non-selected line has no effect
    for (int k = 0; k < 4; k++) begin
      write_cfg(1'b1, 1'b0, 1, k);
      pulse_trig(4'(1 << ((k + 1) % 4)));
      check(busy_o == 1'b0, "R1 other source ignored", int'(busy_o), 0);
      pulse_trig(4'(1 << k));
      check(busy_o == 1'b1, "R1 selected source starts", int'(busy_o), 1);
      write_cfg(1'b1, 1'b0, 1, k);
      check(busy_o == 1'b0, "R4 abort in acquisition", int'(busy_o), 0);
      wait_back();
    end

    // R4 and R8 abort keeps the last completed result
    keep = result;
    vin = 12'h3C3;
    write_cfg(1'b1, 1'b0, 0, 0);
    d0 = done_seen;
    write_cfg(1'b1, 1'b1, 0, 0);
    wait_busy_ticks(5);
    write_cfg(1'b1, 1'b0, 0, 0);
    check(busy_o == 1'b0, "R4 abort clears busy", int'(busy_o), 0);
    check(result == keep, "R8 result kept", int'(result), int'(keep));
    wait_back();
    check(wait_ticks == 2, "R7 wait after abort", wait_ticks, 2);
    check(done_seen == d0, "R4 no done on abort", done_seen - d0, 0);

    // R8 abort keeps a software-written value
    write_res(16'h1234);
    check(result == 16'h1234, "R8 software write", int'(result), 16'h1234);
    write_cfg(1'b1, 1'b1, 0, 0);
    wait_busy_ticks(8);
    write_cfg(1'b0, 1'b0, 0, 0);
    check(busy_o == 1'b0 && result == 16'h1234, "R8 written value kept", int'(result), 16'h1234);
    wait_busy_ticks(0);
    repeat (12) @(negedge clk); #1;

    // R10 triggers while busy and during the wait are dropped
    vin = 12'h5A5;
    write_cfg(1'b1, 1'b0, 0, 2);
    pulse_trig(4'b0100);
    wait_busy_ticks(3);
    pulse_trig(4'b0100);
    wait_done();
    check(result == 16'h05A5, "R10 result unaffected", int'(result), 16'h05A5);
    pulse_trig(4'b0100);
    check(busy_o == 1'b0, "R10 trigger in wait dropped", int'(busy_o), 0);
    wait_back();
    repeat (8) @(negedge clk); #1;
    check(busy_o == 1'b0, "R10 nothing queued", int'(busy_o), 0);

    // Random conversions
    for (int n = 0; n < 16; n++) begin
      run_conv(12'($urandom % 4096), int'($urandom % 8), int'($urandom % 4), 1'($urandom % 2));
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule